// File: doc/BRIEF.md
# Ethernet receive address filter

This block watches the first six bytes of every incoming frame, which carry the destination address, and decides whether the frame is kept. A frame can be kept for four reasons, each with its own enable bit:
- an accept-everything (promiscuous) mode;
- an exact match against the programmed station address;
- the all-ones broadcast address;
- a multicast address whose hash bin is set in a 64-bit filter mask.

The hash is taken from the top six bits of a CRC-32. The CRC is run bit-serially over the six address bytes, least significant bit of each byte first.

A small write port loads five configuration words: two for the station address, two for the hash mask and one for the accept enables. The destination bytes arrive one per clock on `rx_byte` with `rx_valid`. The first byte is marked by `rx_sof`. One cycle after the sixth byte is taken, `dec_done` pulses for a single cycle. In that cycle `dec_accept` gives the verdict and `dec_status` carries the match flags.

Top module: `rx_addr_filter`

## Requirements
- R1: A write with `cfg_we` high stores `cfg_wdata` in the word chosen by `cfg_sel`:
  - 0: station bytes 0..3, with byte 0 in bits 7:0 and byte 3 in bits 31:24.
  - 1: station bytes 4 and 5 in bits 7:0 and 15:8.
  - 2: hash mask bits 31:0.
  - 3: hash mask bits 63:32.
  - 4: accept enables in bits 3:0.
- R2: The hash bin is CRC bits 31:26, taken after all six bytes have been processed. The CRC starts at all ones. Each byte is taken least significant bit first. At each bit, the feedback is CRC bit 31 XOR the data bit. The CRC then shifts left one place and, when the feedback is 1, is XORed with 0x04C11DB7.
- R3: `dec_done` is high for exactly one cycle, in the cycle after the clock edge that takes the sixth byte. While `dec_done` is low, `dec_accept` and `dec_status` are zero.
- R4: A byte with `rx_valid` and `rx_sof` high always starts a new address, discarding any partial one. Valid bytes without `rx_sof` are ignored before the first start and after the sixth byte, and produce no `dec_done`.
- R5: If all six bytes equal the station address, status bit 14 (physical match) is set. The frame is accepted when enable bit 1 is set.
- R6: If all six bytes are 0xFF, status bit 13 (broadcast) is set. The frame is accepted when enable bit 3 is set. Such a frame never sets bit 15 and is never accepted through the hash, whatever the mask holds.
- R7: A frame whose first byte has bit 0 set, and which is not broadcast, is multicast. If the hash mask bit selected by its bin is 1, status bit 15 is set. The frame is then accepted when enable bit 2 is set. A clear mask bit, or bit 0 of the first byte clear, leaves bit 15 clear.
- R8: With enable bit 0 set, every completed frame is accepted, and status bits 13 to 15 are still reported as R5 to R7 define them.
- R9: After reset, the station address, hash mask and enables are zero, and all outputs are low.
- R10: A match whose enable bit is clear still sets its status flag, but does not by itself cause acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_sel | input | 3 | Configuration word select (0..4) |
| cfg_wdata | input | 32 | Configuration write data |
| rx_valid | input | 1 | Destination byte valid |
| rx_sof | input | 1 | Marks the first destination byte |
| rx_byte | input | 8 | Destination byte, first byte on the wire first |
| dec_done | output | 1 | One-cycle strobe: decision valid |
| dec_accept | output | 1 | Frame accepted |
| dec_status | output | 16 | Bit 13 broadcast, bit 14 station match, bit 15 multicast hit; other bits zero |

## Verification
The decision for one address and the capture of the next address's first byte can fall in the same cycle. This happens when a start byte arrives on the clock right after a sixth byte. The bench provokes it by sending a station-match frame and a broadcast frame back to back with no idle cycle between them. It checks that the first frame's verdict and flags appear exactly while the second frame's start byte is presented. It then checks that the second frame's verdict comes out intact and unaffected by the first, six cycles later.

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
  parameter logic [31:0] POLY = 32'h04C11DB7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  input  logic        rx_valid,
  input  logic        rx_sof,
  input  logic [7:0]  rx_byte,
  output logic        dec_done,
  output logic        dec_accept,
  output logic [15:0] dec_status
);
  localparam int NBYTES = 6;
  localparam int HBITS  = 6;
  localparam int NHASH  = 1 << HBITS;

  logic [47:0]      sta_q;
  logic [NHASH-1:0] hash_q;
  logic [3:0]       rcfg_q;
  logic [2:0]       cnt_q;
  logic [31:0]      crc_q;
  logic             phys_q, bc_q, mc_q;

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    logic        fb;
    r = c;
    for (int k = 0; k < 8; k++) begin
      fb = r[31] ^ d[k];
      r  = {r[30:0], 1'b0} ^ (fb ? POLY : 32'h0);
    end
    return r;
  endfunction

  logic [2:0]  idx;
  logic [47:0] sta_sh;
  logic [31:0] crc_nx;
  logic        take, last, phys_nx, bc_nx, mc_nx, is_mc, mhit, acc;

  assign take    = rx_valid && (rx_sof || cnt_q < 3'(NBYTES));
  assign idx     = rx_sof ? 3'd0 : cnt_q;
  assign last    = take && idx == 3'(NBYTES - 1);
  assign sta_sh  = sta_q >> (8 * idx);
  assign crc_nx  = crc_byte(rx_sof ? 32'hFFFF_FFFF : crc_q, rx_byte);
  assign phys_nx = (rx_sof || phys_q) && rx_byte == sta_sh[7:0];
  assign bc_nx   = (rx_sof || bc_q) && rx_byte == 8'hFF;
  assign mc_nx   = rx_sof ? rx_byte[0] : mc_q;
  assign is_mc   = mc_nx && !bc_nx;
  assign mhit    = is_mc && hash_q[crc_nx[31:32-HBITS]];
  assign acc     = rcfg_q[0] | (rcfg_q[1] & phys_nx) | (rcfg_q[3] & bc_nx) | (rcfg_q[2] & mhit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sta_q  <= '0;
      hash_q <= '0;
      rcfg_q <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        3'd0: sta_q[31:0]   <= cfg_wdata;
        3'd1: sta_q[47:32]  <= cfg_wdata[15:0];
        3'd2: hash_q[31:0]  <= cfg_wdata;
        3'd3: hash_q[63:32] <= cfg_wdata;
        3'd4: rcfg_q        <= cfg_wdata[3:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= 3'(NBYTES);
      crc_q  <= '1;
      phys_q <= 1'b0;
      bc_q   <= 1'b0;
      mc_q   <= 1'b0;
    end else if (take) begin
      cnt_q  <= idx + 3'd1;
      crc_q  <= crc_nx;
      phys_q <= phys_nx;
      bc_q   <= bc_nx;
      mc_q   <= mc_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_done   <= 1'b0;
      dec_accept <= 1'b0;
      dec_status <= '0;
    end else begin
      dec_done   <= last;
      dec_accept <= last && acc;
      dec_status <= last ? {mhit, phys_nx, bc_nx, 13'b0} : 16'h0;
    end
  end
endmodule

module rx_addr_filter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_valid,
  input logic        rx_sof,
  input logic        aap,
  input logic        dec_done,
  input logic        dec_accept,
  input logic [15:0] dec_status
);
  logic [2:0] n_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) n_q <= 3'd6;
    else if (rx_valid && rx_sof) n_q <= 3'd1;
    else if (rx_valid && n_q < 3'd6) n_q <= n_q + 3'd1;
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) dec_done |=> !dec_done); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !dec_done |-> (!dec_accept && dec_status == 16'h0)); // R3
  AST_DONE_AFTER_SIX: assert property (@(posedge clk) disable iff (!rst_n) dec_done |-> $past(rx_valid && !rx_sof && n_q == 3'd5)); // R4
  AST_ALL_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) (dec_done && $past(aap)) |-> dec_accept); // R8
  AST_BC_NOT_MC: assert property (@(posedge clk) disable iff (!rst_n) dec_status[13] |-> !dec_status[15]); // R6
  AST_NO_FLAG_REJECT: assert property (@(posedge clk) disable iff (!rst_n) (dec_done && !$past(aap) && dec_status[15:13] == 3'b000) |-> !dec_accept); // R10
endmodule

bind rx_addr_filter rx_addr_filter_chk chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof), .aap(rcfg_q[0]),
  .dec_done(dec_done), .dec_accept(dec_accept), .dec_status(dec_status)
);

// File: tb/rx_addr_filter_test.sv
module rx_addr_filter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic rx_valid = 1'b0, rx_sof = 1'b0;
  logic [7:0] rx_byte = '0;
  logic dec_done, dec_accept;
  logic [15:0] dec_status;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  rx_addr_filter uut (.*);

  localparam logic [47:0] STA = 48'h02_11_22_33_44_55;
  localparam logic [47:0] BC  = 48'hFF_FF_FF_FF_FF_FF;
  localparam logic [47:0] MC1 = 48'h01_00_5E_00_00_01;

  // {flags mc,ph,bc[57:55], accept[54], hash select[53:52], enables[51:48], address[47:0]}
  // hash select: 0 none, 1 all bins, 2 only own bin, 3 all but own bin
  localparam int NV = 15;
  localparam logic [57:0] VEC [NV] = '{
    {3'b010, 1'b1, 2'd0, 4'b0010, STA},                // R5 R1
    {3'b010, 1'b0, 2'd0, 4'b0000, STA},                // R10
    {3'b000, 1'b0, 2'd1, 4'b1110, 48'h02_11_22_33_44_56}, // R5
    {3'b000, 1'b0, 2'd0, 4'b0010, 48'h02_11_22_33_45_55}, // R1 byte 4 position
    {3'b001, 1'b1, 2'd0, 4'b1000, BC},                 // R6
    {3'b001, 1'b0, 2'd1, 4'b0110, BC},                 // R6 not multicast
    {3'b100, 1'b1, 2'd2, 4'b0100, MC1},                // R7 R2
    {3'b000, 1'b0, 2'd3, 4'b0100, MC1},                // R7 R2 other bins only
    {3'b100, 1'b0, 2'd2, 4'b0000, MC1},                // R10
    {3'b000, 1'b0, 2'd1, 4'b0100, 48'h00_00_5E_00_00_01}, // R7 bit0 clear
    {3'b000, 1'b1, 2'd0, 4'b0001, 48'h02_11_22_33_44_56}, // R8
    {3'b010, 1'b1, 2'd0, 4'b0001, STA},                // R8
    {3'b100, 1'b1, 2'd2, 4'b0101, 48'h33_33_00_00_00_01}, // R8 R7
    {3'b001, 1'b1, 2'd0, 4'b0001, BC},                 // R8 R6
    {3'b100, 1'b1, 2'd2, 4'b1100, 48'hFF_FF_FF_FF_FF_FE}  // R7 R6 near broadcast
  };

  function automatic logic [5:0] bin_of(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    logic fb;
    for (int i = 0; i < 6; i++)
      for (int k = 0; k < 8; k++) begin
        fb = c[31] ^ a[47 - 8*i - 7 + k];
        c = c << 1;
        if (fb) c = c ^ 32'h04C11DB7;
      end
    return c[31:26];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic push(input logic [7:0] b, input logic s);
    @(negedge clk); rx_valid = 1'b1; rx_sof = s; rx_byte = b;
  endtask

  task automatic idle();
    @(negedge clk); rx_valid = 1'b0; rx_sof = 1'b0;
  endtask

  task automatic frame(input logic [47:0] a);
    for (int i = 0; i < 6; i++) push(a[47 - 8*i -: 8], i == 0);
  endtask

  task automatic frame_chk(input string tag, input logic [47:0] a, input logic ea, input logic [2:0] ef);
    frame(a);
    idle();
    chk({tag, " done"}, 32'(dec_done), 32'd1);
    chk({tag, " accept"}, 32'(dec_accept), 32'(ea));
    chk({tag, " status"}, 32'(dec_status), 32'({ef, 13'b0}));
    @(negedge clk);
    chk({tag, " done one cycle R3"}, 32'(dec_done), 32'd0);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] hm;
    logic [5:0] b;
    repeat (3) @(negedge clk);
    chk("R9 reset done", 32'(dec_done), 32'd0);
    chk("R9 reset accept", 32'(dec_accept), 32'd0);
    chk("R9 reset status", 32'(dec_status), 32'd0);
    rst_n = 1'b1;
    // R4: bytes before any start are ignored
    for (int i = 0; i < 8; i++) begin
      push(8'h00, 1'b0);
      chk("R4 no start no done", 32'(dec_done), 32'd0);
    end
    idle();
    // R9: zero station, zero enables after reset
    frame_chk("R9 reset state", 48'h0, 1'b0, 3'b010);

    wr(3'd0, {STA[23:16], STA[31:24], STA[39:32], STA[47:40]});
    wr(3'd1, {16'h0, STA[7:0], STA[15:8]});

    for (int v = 0; v < NV; v++) begin
      b = bin_of(VEC[v][47:0]);
      case (VEC[v][53:52])
        2'd0: hm = 64'h0;
        2'd1: hm = '1;
        2'd2: hm = 64'h1 << b;
        default: hm = ~(64'h1 << b);
      endcase
      wr(3'd2, hm[31:0]);
      wr(3'd3, hm[63:32]);
      wr(3'd4, {28'h0, VEC[v][51:48]});
      frame_chk($sformatf("vector %0d R1 R2 R5 R6 R7 R8 R10", v), VEC[v][47:0], VEC[v][54], VEC[v][57:55]);
    end

    // R4: start restarts a partial address
    wr(3'd2, 32'h0); wr(3'd3, 32'h0); wr(3'd4, 32'h2);
    push(8'h02, 1'b1); push(8'hAA, 1'b0); push(8'hBB, 1'b0);
    frame_chk("R4 restart", STA, 1'b1, 3'b010);

    // R4: bytes past the sixth are ignored
    for (int i = 0; i < 6; i++) begin
      push(8'h55, 1'b0);
      chk("R4 extra bytes no done", 32'(dec_done), 32'd0);
    end
    idle();
    @(negedge clk);
    chk("R4 extra bytes no done tail", 32'(dec_done), 32'd0);

    // R3: back-to-back frames, decision coincides with next start byte
    wr(3'd4, 32'hA);
    frame(STA);
    push(8'hFF, 1'b1);
    chk("R3 back-to-back done A", 32'(dec_done), 32'd1);
    chk("R3 back-to-back accept A", 32'(dec_accept), 32'd1);
    chk("R3 back-to-back status A", 32'(dec_status), 32'h4000);
    for (int i = 1; i < 6; i++) begin
      push(8'hFF, 1'b0);
      chk("R3 back-to-back quiet", 32'(dec_done), 32'd0);
    end
    idle();
    chk("R3 back-to-back done B", 32'(dec_done), 32'd1);
    chk("R3 back-to-back accept B", 32'(dec_accept), 32'd1);
    chk("R3 back-to-back status B", 32'(dec_status), 32'h2000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule